// File: doc/BRIEF.md
# IDE Timing Configuration Window

This block sits on the I/O address decode of a legacy IDE command block. In normal operation every access in the eight-byte range is handed to the attached drive. A fixed unlock sequence turns the same range into a hidden window. While the window is open, the accesses reach a small set of timing registers and the drive sees none of them. A byte write of a closing key returns the range to normal decode.

The window holds two timing banks. Each bank has a read-cycle value, a write-cycle value and an address-setup value. A bank-select register steers the timing loads: software first writes a drive number to it, then loads the read and write timing, and finally writes it again with the address-setup value in the upper nibble. A control register maps the banks onto the drives. The block watches the drive-select bit of the device/head register on normal writes, and it presents the timing of the bank that serves the selected drive on its outputs for the strobe generator.

The unlock logic is a four-state machine. ST_LOCKED is normal decode. A 16-bit read at offset 1 moves it to ST_RD1 (transition T_FIRST_READ). A second such read moves it to ST_RD2 (T_SECOND_READ). In ST_RD2 a further 16-bit read at offset 1 keeps the state (T_REPEAT_READ), and a byte write of 0x03 at offset 2 moves it to ST_OPEN (T_OPEN_KEY). From ST_LOCKED, ST_RD1 or ST_RD2, any other access returns the machine to ST_LOCKED (T_ABORT). In ST_OPEN a byte write of 0x83 at offset 2 returns it to ST_LOCKED (T_CLOSE_KEY), and every other access keeps it in ST_OPEN (T_WINDOW_ACCESS).

Top module: `ide_cfg_window`

## Requirements
- R1: After reset the window is closed and the active outputs show the slowest timing: read and write timing 0xFF and setup 0xF. The control register and the bank select read back as 0 once the window is opened.
- R2: Two consecutive 16-bit reads at offset 1, followed by a byte write of 0x03 at offset 2, open the window, and `cfg_open` is high from the clock edge of that write onward. The three accesses of the sequence still go to the drive.
- R3: If any other access comes between the steps, the sequence is abandoned. Such an access can be of a different offset, width or direction, or a key write with the wrong value or with 16-bit width. The only exception is a further 16-bit read at offset 1 after the second read, which counts as a repeat of that read.
- R4: While the window is open, `io_to_drive` stays low for every access. Writes at offset 6 load the bank select and do not change the tracked drive select.
- R5: Only a byte write of 0x83 at offset 2 closes the window. Every other byte value at offset 2, and a 16-bit write of 0x83 there, leave the window open.
- R6: A window write at offset 6 sets the bank select to bit 0 and stores bits 7:4 as the setup of that bank. A window read at offset 6 returns {setup of selected bank, 3'b000, bank select}.
- R7: Window writes at offset 0 and offset 1 load the read-cycle and write-cycle timing of the selected bank. Window reads at those offsets return the stored values.
- R8: The control register sits at window offset 3 and reads back what was written. When bit 0 of the control register is 1, drive 0 uses bank 0 and drive 1 uses bank 1. When bit 0 is 0, both drives use bank 0.
- R9: A window read at offset 5 returns the clock strap in bit 0 (0 means 33 MHz, 1 means 25 MHz) and zeros in bits 7:1.
- R10: The active outputs follow bit 4 of the last write at offset 6 made through normal decode. Bit 4 selects drive 1.
- R11: `io_rdata` is 0 while the window is closed. Window offsets 2, 4 and 7 read as 0, and writes at 4 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | One-cycle access strobe on the command block |
| io_write | input | 1 | 1 = write, 0 = read |
| io_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_addr | input | 3 | Offset within the command block |
| io_wdata | input | 8 | Write data (low byte) |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| io_rdata | output | 8 | Window read data, 0 when closed |
| io_to_drive | output | 1 | The current access is passed to the drive |
| cfg_open | output | 1 | Window is open |
| act_rd_tim | output | 8 | Active read-cycle timing |
| act_wr_tim | output | 8 | Active write-cycle timing |
| act_setup | output | 4 | Active address-setup value |

## Verification
The bench builds the block with its defaults: two banks, 8-bit data, a 3-bit offset and a 4-bit setup field. With these values the whole offset space can be swept. It interrupts the unlock sequence with every offset, width and direction at both interior steps, writes all 256 byte values to the key offset while the window is open, and loads all sixteen setup codes. With both banks loaded with distinct values, every combination of control bit 0 and drive select points to a bank whose outputs are unambiguous.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_RD1    = 2'd1,
        ST_RD2    = 2'd2,
        ST_OPEN   = 2'd3
    } win_state_t;

    // Unlock / relock protocol on the command block
    localparam int          OFS_UNLOCK_RD = 1;
    localparam int          OFS_KEY       = 2;
    localparam logic [7:0]  KEY_OPEN      = 8'h03;
    localparam logic [7:0]  KEY_CLOSE     = 8'h83;

    // Window register offsets
    localparam int          OFS_RDTIM     = 0;
    localparam int          OFS_WRTIM     = 1;
    localparam int          OFS_CTRL      = 3;
    localparam int          OFS_STRAP     = 5;
    localparam int          OFS_MISC      = 6;

    // Normal-decode device/head register and its drive bit
    localparam int          OFS_DEVHEAD   = 6;
    localparam int          DEV_BIT       = 4;

endpackage

// File: rtl/ide_win_unlock.sv
module ide_win_unlock
    import ide_win_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              win_open
);

    win_state_t state_q, state_d;

    logic is_unlock_rd;
    logic is_key_byte;
    logic is_key_open;
    logic is_key_close;

    assign is_unlock_rd = acc_valid && !acc_write && acc_wide
                          && (acc_addr == ADDR_W'(OFS_UNLOCK_RD));
    assign is_key_byte  = acc_valid && acc_write && !acc_wide
                          && (acc_addr == ADDR_W'(OFS_KEY));
    assign is_key_open  = is_key_byte && (acc_wdata == DATA_W'(KEY_OPEN));
    assign is_key_close = is_key_byte && (acc_wdata == DATA_W'(KEY_CLOSE));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (is_unlock_rd)   state_d = ST_RD1;      // T_FIRST_READ
            end
            ST_RD1: begin
                if (is_unlock_rd)   state_d = ST_RD2;      // T_SECOND_READ
                else if (acc_valid) state_d = ST_LOCKED;   // T_ABORT
            end
            ST_RD2: begin
                if (is_unlock_rd)     state_d = ST_RD2;    // T_REPEAT_READ
                else if (is_key_open) state_d = ST_OPEN;   // T_OPEN_KEY
                else if (acc_valid)   state_d = ST_LOCKED; // T_ABORT
            end
            ST_OPEN: begin
                if (is_key_close)   state_d = ST_LOCKED;   // T_CLOSE_KEY
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_OPEN: win_open = 1'b1;
            default: win_open = 1'b0;
        endcase
    end

    // R2: the window only opens on the key byte write
    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(acc_valid && acc_write && !acc_wide
            && acc_addr == ADDR_W'(OFS_KEY) && acc_wdata == DATA_W'(KEY_OPEN)));

    // R5: the close key always shuts an open window
    p_close_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && is_key_close) |=> !win_open);

endmodule

// File: rtl/ide_win_banks.sv
module ide_win_banks #(
    parameter int NBANK      = 2,
    parameter int DATA_W     = 8,
    parameter int SETUP_W    = 4,
    parameter logic [DATA_W-1:0]  SLOW_TIM   = '1,
    parameter logic [SETUP_W-1:0] SLOW_SETUP = '1,
    localparam int BW        = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_rdtim,
    input  logic                               wr_wrtim,
    input  logic                               wr_misc,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [BW-1:0]                      load_sel,
    output logic [NBANK-1:0][DATA_W-1:0]       rd_tim_all,
    output logic [NBANK-1:0][DATA_W-1:0]       wr_tim_all,
    output logic [NBANK-1:0][SETUP_W-1:0]      setup_all
);

    logic [BW-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (wr_misc) sel_q <= wdata[BW-1:0];
    end
    assign load_sel = sel_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0]  rd_q;
        logic [DATA_W-1:0]  wr_q;
        logic [SETUP_W-1:0] su_q;
        logic               hit_cur;
        logic               hit_new;

        assign hit_cur = (sel_q == BW'(b));
        assign hit_new = (wdata[BW-1:0] == BW'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= SLOW_TIM;
                wr_q <= SLOW_TIM;
                su_q <= SLOW_SETUP;
            end else begin
                if (wr_rdtim && hit_cur) rd_q <= wdata;
                if (wr_wrtim && hit_cur) wr_q <= wdata;
                if (wr_misc  && hit_new) su_q <= wdata[DATA_W-1 -: SETUP_W];
            end
        end

        assign rd_tim_all[b] = rd_q;
        assign wr_tim_all[b] = wr_q;
        assign setup_all[b]  = su_q;

        // R7: timing loads land in the selected bank
        p_rd_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_rdtim && sel_q == BW'(b)) |=> rd_tim_all[b] == $past(wdata));
        p_wr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_wrtim && sel_q == BW'(b)) |=> wr_tim_all[b] == $past(wdata));
    end

    // R6: bank-select write takes bit 0
    p_misc_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_misc |=> load_sel == $past(wdata[BW-1:0]));

endmodule

// File: rtl/ide_win_rdmux.sv
module ide_win_rdmux
    import ide_win_pkg::*;
#(
    parameter int NBANK   = 2,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 4,
    localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int GAP_W  = DATA_W - SETUP_W - BW
) (
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BW-1:0]                 load_sel,
    input  logic [NBANK-1:0][DATA_W-1:0]  rd_tim_all,
    input  logic [NBANK-1:0][DATA_W-1:0]  wr_tim_all,
    input  logic [NBANK-1:0][SETUP_W-1:0] setup_all,
    input  logic [DATA_W-1:0]             ctrl,
    input  logic                          strap,
    output logic [DATA_W-1:0]             rdata
);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(OFS_RDTIM): rdata = rd_tim_all[load_sel];
                ADDR_W'(OFS_WRTIM): rdata = wr_tim_all[load_sel];
                ADDR_W'(OFS_CTRL):  rdata = ctrl;
                ADDR_W'(OFS_STRAP): rdata = DATA_W'(strap);
                ADDR_W'(OFS_MISC):  rdata = {setup_all[load_sel], GAP_W'(0), load_sel};
                default:            rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ide_win_outsel.sv
module ide_win_outsel #(
    parameter int NBANK   = 2,
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 4,
    localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                          split_map,
    input  logic                          drv_sel,
    input  logic [NBANK-1:0][DATA_W-1:0]  rd_tim_all,
    input  logic [NBANK-1:0][DATA_W-1:0]  wr_tim_all,
    input  logic [NBANK-1:0][SETUP_W-1:0] setup_all,
    output logic [DATA_W-1:0]             act_rd_tim,
    output logic [DATA_W-1:0]             act_wr_tim,
    output logic [SETUP_W-1:0]            act_setup
);

    logic [BW-1:0] eff_bank;

    always_comb begin
        eff_bank   = split_map ? BW'(drv_sel) : '0;
        act_rd_tim = rd_tim_all[eff_bank];
        act_wr_tim = wr_tim_all[eff_bank];
        act_setup  = setup_all[eff_bank];
    end

endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
    import ide_win_pkg::*;
#(
    parameter int NBANK   = 2,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 4,
    localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic              io_wide,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              strap_clk25,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_to_drive,
    output logic              cfg_open,
    output logic [DATA_W-1:0] act_rd_tim,
    output logic [DATA_W-1:0] act_wr_tim,
    output logic [SETUP_W-1:0] act_setup
);

    logic                          win_open;
    logic                          win_wr;
    logic                          wr_rdtim, wr_wrtim, wr_misc, wr_ctrl;
    logic [DATA_W-1:0]             ctrl_q;
    logic                          drv_sel_q;
    logic [BW-1:0]                 load_sel;
    logic [NBANK-1:0][DATA_W-1:0]  rd_tim_all;
    logic [NBANK-1:0][DATA_W-1:0]  wr_tim_all;
    logic [NBANK-1:0][SETUP_W-1:0] setup_all;

    ide_win_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (io_valid),
        .acc_write (io_write),
        .acc_wide  (io_wide),
        .acc_addr  (io_addr),
        .acc_wdata (io_wdata),
        .win_open  (win_open)
    );

    // Decode steering
    assign win_wr   = io_valid && io_write && win_open;
    assign wr_rdtim = win_wr && (io_addr == ADDR_W'(OFS_RDTIM));
    assign wr_wrtim = win_wr && (io_addr == ADDR_W'(OFS_WRTIM));
    assign wr_ctrl  = win_wr && (io_addr == ADDR_W'(OFS_CTRL));
    assign wr_misc  = win_wr && (io_addr == ADDR_W'(OFS_MISC));

    assign io_to_drive = io_valid && !win_open;
    assign cfg_open    = win_open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            drv_sel_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= io_wdata;
            if (io_valid && io_write && !win_open && io_addr == ADDR_W'(OFS_DEVHEAD))
                drv_sel_q <= io_wdata[DEV_BIT];
        end
    end

    ide_win_banks #(
        .NBANK(NBANK), .DATA_W(DATA_W), .SETUP_W(SETUP_W)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_rdtim   (wr_rdtim),
        .wr_wrtim   (wr_wrtim),
        .wr_misc    (wr_misc),
        .wdata      (io_wdata),
        .load_sel   (load_sel),
        .rd_tim_all (rd_tim_all),
        .wr_tim_all (wr_tim_all),
        .setup_all  (setup_all)
    );

    ide_win_rdmux #(
        .NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_W(SETUP_W)
    ) u_rdmux (
        .rd_en      (io_valid && !io_write && win_open),
        .addr       (io_addr),
        .load_sel   (load_sel),
        .rd_tim_all (rd_tim_all),
        .wr_tim_all (wr_tim_all),
        .setup_all  (setup_all),
        .ctrl       (ctrl_q),
        .strap      (strap_clk25),
        .rdata      (io_rdata)
    );

    ide_win_outsel #(
        .NBANK(NBANK), .DATA_W(DATA_W), .SETUP_W(SETUP_W)
    ) u_outsel (
        .split_map  (ctrl_q[0]),
        .drv_sel    (drv_sel_q),
        .rd_tim_all (rd_tim_all),
        .wr_tim_all (wr_tim_all),
        .setup_all  (setup_all),
        .act_rd_tim (act_rd_tim),
        .act_wr_tim (act_wr_tim),
        .act_setup  (act_setup)
    );

    // R4: window accesses never move the tracked drive select
    p_drvsel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && io_valid) |=> $stable(drv_sel_q));

    // R8: control register only changes on its own window write
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));

    // R4: drive is never addressed while the window is open
    p_no_drive_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win_open && !(io_valid && io_write && !io_wide
              && io_addr == ADDR_W'(OFS_KEY) && io_wdata == DATA_W'(KEY_CLOSE)))
        |-> !io_to_drive);

endmodule

// File: tb/ide_cfg_window_tb.sv
module ide_cfg_window_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_valid = 1'b0;
    logic       io_write = 1'b0;
    logic       io_wide = 1'b0;
    logic [2:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       strap_clk25 = 1'b0;
    logic [7:0] io_rdata;
    logic       io_to_drive;
    logic       cfg_open;
    logic [7:0] act_rd_tim;
    logic [7:0] act_wr_tim;
    logic [3:0] act_setup;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ide_cfg_window u_dut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_wide(io_wide), .io_addr(io_addr), .io_wdata(io_wdata),
        .strap_clk25(strap_clk25), .io_rdata(io_rdata), .io_to_drive(io_to_drive),
        .cfg_open(cfg_open), .act_rd_tim(act_rd_tim), .act_wr_tim(act_wr_tim),
        .act_setup(act_setup)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [7:0] last_rd;
    logic       last_td;

    task automatic acc(input bit wr, input bit wd, input int a, input logic [7:0] d);
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_wide = wd;
        io_addr = 3'(a); io_wdata = d;
        #2;
        last_rd = io_rdata;
        last_td = io_to_drive;
        @(posedge clk);
        #1;
        io_valid = 1'b0;
    endtask

    task automatic do_unlock();
        acc(0, 1, 1, 8'h00);
        acc(0, 1, 1, 8'h00);
        acc(1, 0, 2, 8'h03);
    endtask

    task automatic do_lock();
        acc(1, 0, 2, 8'h83);
    endtask

    logic [7:0] ert [2];
    logic [7:0] ewt [2];
    logic [3:0] esu [2];

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 open", cfg_open, 0);
        chk("R1 act_rd", act_rd_tim, 8'hFF);
        chk("R1 act_wr", act_wr_tim, 8'hFF);
        chk("R1 act_setup", act_setup, 4'hF);

        // R11: locked read returns zero and goes to drive
        acc(0, 0, 0, 8'h00);
        chk("R11 locked rdata", last_rd, 0);
        chk("R11 locked to_drive", last_td, 1);

        // R2: unlock sequence, each step forwarded
        acc(0, 1, 1, 8'h00); chk("R2 step1 to_drive", last_td, 1);
        acc(0, 1, 1, 8'h00); chk("R2 step2 to_drive", last_td, 1);
        chk("R2 not yet open", cfg_open, 0);
        acc(1, 0, 2, 8'h03); chk("R2 key to_drive", last_td, 1);
        chk("R2 open", cfg_open, 1);
        acc(0, 0, 3, 8'h00); chk("R1 ctrl reset", last_rd, 0);
        acc(0, 0, 0, 8'h00); chk("R1 bank0 rd reset", last_rd, 8'hFF);
        acc(0, 0, 6, 8'h00); chk("R1 misc reset", last_rd, 8'hF0);

        // R4: every access in window is hidden from drive
        for (int a = 0; a < 8; a++) begin
            acc(0, 0, a, 8'h00);
            chk("R4 window read to_drive", last_td, 0);
        end

        // R9: strap
        for (int s = 0; s < 2; s++) begin
            strap_clk25 = 1'(s);
            acc(0, 0, 5, 8'h00);
            chk("R9 strap", last_rd, 32'(s));
        end

        // R6: every setup code into bank 0
        for (int su = 0; su < 16; su++) begin
            acc(1, 0, 6, 8'((su << 4) | 0));
            acc(0, 0, 6, 8'h00);
            chk("R6 misc readback", last_rd, 32'(su << 4));
        end

        // R7/R6: load both banks with distinct values
        for (int b = 0; b < 2; b++) begin
            ert[b] = 8'(8'h20 + b * 8'h26);
            ewt[b] = 8'(8'h31 + b * 8'h15);
            esu[b] = 4'(1 + b * 2);
            acc(1, 0, 6, 8'(b));
            acc(1, 0, 0, ert[b]);
            acc(1, 0, 1, ewt[b]);
            acc(1, 0, 6, 8'({esu[b], 4'(b)}));
        end
        for (int b = 0; b < 2; b++) begin
            acc(1, 0, 6, 8'({esu[b], 4'(b)}));
            acc(0, 0, 0, 8'h00); chk("R7 rd tim readback", last_rd, ert[b]);
            acc(0, 0, 1, 8'h00); chk("R7 wr tim readback", last_rd, ewt[b]);
            acc(0, 0, 6, 8'h00); chk("R6 misc sel readback", last_rd, {esu[b], 3'b000, 1'(b)});
        end

        // R11: unused offsets read zero, writes change nothing
        acc(1, 0, 4, 8'hAA);
        acc(1, 0, 7, 8'h55);
        for (int a = 2; a < 8; a++) begin
            if (a == 2 || a == 4 || a == 7) begin
                acc(0, 0, a, 8'h00);
                chk("R11 unused read", last_rd, 0);
            end
        end
        acc(0, 0, 0, 8'h00); chk("R11 bank intact rd", last_rd, ert[1]);
        acc(0, 0, 3, 8'h00); chk("R11 ctrl intact", last_rd, 0);

        // R8: mapping sweep over control value and drive select
        for (int c = 0; c < 3; c++) begin
            logic [7:0] cv;
            cv = (c == 0) ? 8'h00 : (c == 1) ? 8'h85 : 8'h84;
            if (!cfg_open) do_unlock();
            acc(1, 0, 3, cv);
            acc(0, 0, 3, 8'h00); chk("R8 ctrl readback", last_rd, cv);
            do_lock();
            chk("R5 closed", cfg_open, 0);
            for (int d = 0; d < 2; d++) begin
                int eb;
                acc(1, 0, 6, 8'(d << 4));
                eb = cv[0] ? d : 0;
                chk("R8/R10 act_rd", act_rd_tim, ert[eb]);
                chk("R8/R10 act_wr", act_wr_tim, ewt[eb]);
                chk("R8/R10 act_setup", act_setup, esu[eb]);
            end
        end

        // R10/R4: window write at offset 6 must not move drive select
        if (!cfg_open) do_unlock();
        acc(1, 0, 3, 8'h85);
        do_lock();
        acc(1, 0, 6, 8'h00);
        chk("R10 drv0 act_rd", act_rd_tim, ert[0]);
        do_unlock();
        acc(1, 0, 6, 8'h10);           // sel bank 0, setup 1
        esu[0] = 4'h1;
        chk("R4 drive select held", act_rd_tim, ert[0]);
        do_lock();
        acc(1, 0, 6, 8'h10);
        chk("R10 drv1 act_rd", act_rd_tim, ert[1]);
        acc(0, 1, 6, 8'h00);            // read at 6 does not change select
        chk("R10 read ignored", act_rd_tim, ert[1]);

        // R5: every byte value at offset 2 while open
        do_unlock();
        for (int v = 0; v < 256; v++) begin
            acc(1, 0, 2, 8'(v));
            chk("R5 key response", cfg_open, (v == 8'h83) ? 0 : 1);
            if (!cfg_open) do_unlock();
        end
        acc(1, 1, 2, 8'h83);
        chk("R5 wide close ignored", cfg_open, 1);
        do_lock();
        chk("R5 closed", cfg_open, 0);

        // R3: interrupt the sequence at each interior step with every access kind
        for (int pos = 0; pos < 2; pos++) begin
            for (int a = 0; a < 8; a++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    for (int wd = 0; wd < 2; wd++) begin
                        bit expo;
                        expo = (a == 1 && wr == 0 && wd == 1);
                        acc(0, 1, 1, 8'h00);
                        if (pos == 1) acc(0, 1, 1, 8'h00);
                        acc(1'(wr), 1'(wd), a, 8'h00);
                        if (pos == 0) acc(0, 1, 1, 8'h00);
                        acc(1, 0, 2, 8'h03);
                        chk("R3 interrupted sequence", cfg_open, 32'(expo));
                        if (cfg_open) do_lock();
                    end
                end
            end
        end
        // R3: wrong key value and wrong key width
        acc(0, 1, 1, 8'h00); acc(0, 1, 1, 8'h00); acc(1, 0, 2, 8'h04);
        acc(1, 0, 2, 8'h03);
        chk("R3 wrong key value", cfg_open, 0);
        acc(0, 1, 1, 8'h00); acc(0, 1, 1, 8'h00); acc(1, 1, 2, 8'h03);
        chk("R3 wide key", cfg_open, 0);
        acc(0, 0, 0, 8'h00);
        chk("R11 locked after abort", last_rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule